// File: doc/BRIEF.md
# Sector Hamming Code Generator and Checker

This block computes a 24-bit single-error-correcting parity code over a sector of bytes as the sector streams across a flash data bus, and classifies the difference between a code held in the spare area and a code freshly computed on read-back. Each chipselect owns its own accumulation context. Software arms a context with its start bit, pushes data through it byte by byte, and then reads the code. Reading the code through the clear strobe wipes the context for the next sector.

The code has two 12-bit halves. The upper half is the XOR of the positions of all set data bits. The lower half is the XOR of the complements of those positions. A position is the byte index followed by the 3-bit bit index. The 24-bit code is inverted, so a fully erased sector yields all ones, just like erased spare bytes. On a single flipped data bit the two halves of the difference are complementary, and the difference names the failing bit directly. A single flipped bit in the stored code leaves exactly one bit set in the difference.

Top module: `sector_hamming_ecc`

## Requirements
- R1: After reset every context's code reads 0xFFFFFF and fix_valid is 0.
- R2: A context's code equals ~{H, L}, where H (bits 23:12) is the XOR of the 12-bit positions {byte_index[8:0], bit[2:0]} of every set data bit, and L (bits 11:0) is the XOR of the bitwise complements of those positions. An all-0xFF sector therefore yields 0xFFFFFF. Bits 7:0 form the first byte written to the spare area.
- R3: A pulse on start_mask[k] clears context k, arms it, and restarts its byte index at 0, even in the middle of a sector.
- R4: A byte with byte_valid set updates only the context named by byte_cs. Bytes sent to a context that is not armed leave its code unchanged.
- R5: Once SECTOR_BYTES bytes have been taken after a start, further bytes leave the code unchanged.
- R6: code_clear clears the context named by code_cs back to 0xFFFFFF and disarms it. Later bytes have no effect until the next start.
- R7: code_out shows, combinationally, the code of the context selected by code_cs.
- R8: A result appears on fix_valid in the cycle after check_valid. When diff = calc_code ^ stored_code is zero, fix_status is 0 (no error).
- R9: When diff[11:0] ^ diff[23:12] is 0xFFF, fix_status is 1 (data bit corrected), fix_byte is diff[23:15] and fix_bit is diff[14:12]. If that offset is not below SECTOR_BYTES, fix_status is 3 instead.
- R10: When diff has exactly one bit set, fix_status is 2 (error in the code only), with fix_byte and fix_bit both 0.
- R11: Any other nonzero diff gives fix_status 3 (uncorrectable), with fix_byte and fix_bit both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_mask | input | NUM_CS | One start bit per chipselect context |
| byte_valid | input | 1 | Data byte strobe |
| byte_cs | input | CS_W | Context that receives the byte |
| byte_data | input | 8 | Data byte |
| code_cs | input | CS_W | Context shown on code_out |
| code_clear | input | 1 | Read-and-clear strobe for the code_cs context |
| code_out | output | 24 | Inverted code of the selected context |
| check_valid | input | 1 | Compare strobe |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code computed on read-back |
| fix_valid | output | 1 | Result valid, one cycle after check_valid |
| fix_status | output | 2 | 0 none, 1 data bit, 2 code bit, 3 uncorrectable |
| fix_byte | output | 9 | Byte offset of the bad data bit |
| fix_bit | output | 3 | Bit index of the bad data bit |

## Verification
The hardest case to reach from the ports is a single-bit data error at every one of the 4096 sector positions. Each such error needs a whole sector written and read back. The bench instead derives the code difference that any single flip produces, {p, ~p}, and feeds each such pair straight into the checker. One end-to-end case also streams a sector with one flipped bit through a context to tie the two halves of the block together. Contexts are driven with interleaved byte streams, overrun bytes and a restart in mid-sector, so the per-chipselect separation and the byte-index bound are both exercised.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int COL_W  = 3;
    localparam int ROW_W  = 9;
    localparam int HALF_W = COL_W + ROW_W;
    localparam int CODE_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        FIX_NONE = 2'd0,
        FIX_DATA = 2'd1,
        FIX_CODE = 2'd2,
        FIX_BAD  = 2'd3
    } fix_e;
endpackage

// File: rtl/ecc_sector_ctx.sv
module ecc_sector_ctx
    import ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clear_i,
    input  logic              byte_en_i,
    input  logic [7:0]        byte_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);

    typedef struct packed {
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } ctx_t;

    ctx_t              ctx_d, ctx_q;
    logic [ROW_W-1:0]  row_d;
    logic [HALF_W-1:0] pos_d;
    logic              take_d;

    always_comb begin
        ctx_d  = ctx_q;
        row_d  = ROW_W'(ctx_q.cnt);
        pos_d  = '0;
        take_d = byte_en_i && ctx_q.armed && (ctx_q.cnt < CNT_W'(SECTOR_BYTES));
        if (take_d) begin
            for (int b = 0; b < 8; b++) begin
                if (byte_i[b]) begin
                    pos_d    = {row_d, COL_W'(b)};
                    ctx_d.hi = ctx_d.hi ^ pos_d;
                    ctx_d.lo = ctx_d.lo ^ ~pos_d;
                end
            end
            ctx_d.cnt = ctx_q.cnt + CNT_W'(1);
        end
        if (start_i || clear_i) begin
            ctx_d.hi    = '0;
            ctx_d.lo    = '0;
            ctx_d.cnt   = '0;
            ctx_d.armed = start_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign code_o = ~{ctx_q.hi, ctx_q.lo};

    assert_wipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || clear_i) |=> (code_o == '1));
    assert_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ctx_q.armed);
    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_q.armed && !start_i && !clear_i) |=> $stable(code_o));
    assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q.cnt <= CNT_W'(SECTOR_BYTES));
    assert_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.cnt == CNT_W'(SECTOR_BYTES) && !start_i && !clear_i) |=> $stable(code_o));
    assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !start_i) |=> !ctx_q.armed);
endmodule

// File: rtl/ecc_code_fix.sv
module ecc_code_fix
    import ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_i,
    input  logic [CODE_W-1:0] stored_i,
    input  logic [CODE_W-1:0] calc_i,
    output logic              valid_o,
    output logic [1:0]        status_o,
    output logic [ROW_W-1:0]  byte_o,
    output logic [COL_W-1:0]  bit_o
);
    typedef struct packed {
        logic             valid;
        fix_e             status;
        logic [ROW_W-1:0] offs;
        logic [COL_W-1:0] bidx;
    } fix_t;

    fix_t              fix_d, fix_q;
    logic [CODE_W-1:0] diff_d;
    logic [HALF_W-1:0] syn_d;
    logic [ROW_W-1:0]  offs_d;

    always_comb begin
        fix_d       = fix_q;
        fix_d.valid = check_i;
        diff_d      = calc_i ^ stored_i;
        syn_d       = diff_d[HALF_W-1:0] ^ diff_d[CODE_W-1:HALF_W];
        offs_d      = diff_d[CODE_W-1:CODE_W-ROW_W];
        if (check_i) begin
            fix_d.offs = '0;
            fix_d.bidx = '0;
            if (diff_d == '0) begin
                fix_d.status = FIX_NONE;
            end else if (syn_d == '1) begin
                if (32'(offs_d) < SECTOR_BYTES) begin
                    fix_d.status = FIX_DATA;
                    fix_d.offs   = offs_d;
                    fix_d.bidx   = diff_d[HALF_W+COL_W-1:HALF_W];
                end else begin
                    fix_d.status = FIX_BAD;
                end
            end else if ($onehot(diff_d)) begin
                fix_d.status = FIX_CODE;
            end else begin
                fix_d.status = FIX_BAD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fix_q <= '{valid: 1'b0, status: FIX_NONE, offs: '0, bidx: '0};
        else        fix_q <= fix_d;
    end

    assign valid_o  = fix_q.valid;
    assign status_o = fix_q.status;
    assign byte_o   = fix_q.offs;
    assign bit_o    = fix_q.bidx;

    assert_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        check_i |=> valid_o);
    assert_noresult_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !check_i |=> !valid_o);
    assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && status_o == 2'(FIX_DATA)) |-> (32'(byte_o) < SECTOR_BYTES));
    assert_codeonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && status_o == 2'(FIX_CODE)) |-> (byte_o == '0 && bit_o == '0));
    assert_bad_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && status_o == 2'(FIX_BAD)) |-> (byte_o == '0 && bit_o == '0));
endmodule

// File: rtl/sector_hamming_ecc.sv
module sector_hamming_ecc
    import ecc_pkg::*;
#(
    parameter int NUM_CS       = 4,
    parameter int SECTOR_BYTES = 512,
    parameter int CS_W         = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CS-1:0] start_mask,
    input  logic              byte_valid,
    input  logic [CS_W-1:0]   byte_cs,
    input  logic [7:0]        byte_data,
    input  logic [CS_W-1:0]   code_cs,
    input  logic              code_clear,
    output logic [23:0]       code_out,
    input  logic              check_valid,
    input  logic [23:0]       stored_code,
    input  logic [23:0]       calc_code,
    output logic              fix_valid,
    output logic [1:0]        fix_status,
    output logic [8:0]        fix_byte,
    output logic [2:0]        fix_bit
);
    logic [CODE_W-1:0] ctx_code [NUM_CS];

    for (genvar k = 0; k < NUM_CS; k++) begin : g_ctx
        logic en_k, clr_k;
        assign en_k  = byte_valid && (byte_cs == CS_W'(k));
        assign clr_k = code_clear && (code_cs == CS_W'(k));

        ecc_sector_ctx #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_mask[k]),
            .clear_i   (clr_k),
            .byte_en_i (en_k),
            .byte_i    (byte_data),
            .code_o    (ctx_code[k])
        );
    end

    always_comb begin
        code_out = '1;
        for (int k = 0; k < NUM_CS; k++) begin
            if (code_cs == CS_W'(k)) code_out = ctx_code[k];
        end
    end

    ecc_code_fix #(.SECTOR_BYTES(SECTOR_BYTES)) u_fix (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_i  (check_valid),
        .stored_i (stored_code),
        .calc_i   (calc_code),
        .valid_o  (fix_valid),
        .status_o (fix_status),
        .byte_o   (fix_byte),
        .bit_o    (fix_bit)
    );

    assert_clearview_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_clear && !start_mask[code_cs] && !$isunknown(code_cs)) |=>
            (code_out == '1 || code_cs != $past(code_cs)));
endmodule

// File: tb/sector_hamming_ecc_bench.sv
module sector_hamming_ecc_bench;
    localparam int NCS = 4;
    localparam int SB  = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  start_mask = '0;
    logic        byte_valid = 1'b0;
    logic [1:0]  byte_cs = '0;
    logic [7:0]  byte_data = '0;
    logic [1:0]  code_cs = '0;
    logic        code_clear = 1'b0;
    logic [23:0] code_out;
    logic        check_valid = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        fix_valid;
    logic [1:0]  fix_status;
    logic [8:0]  fix_byte;
    logic [2:0]  fix_bit;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sector_hamming_ecc #(.NUM_CS(NCS), .SECTOR_BYTES(SB)) u_sector_hamming_ecc (
        .clk(clk), .rst_n(rst_n), .start_mask(start_mask),
        .byte_valid(byte_valid), .byte_cs(byte_cs), .byte_data(byte_data),
        .code_cs(code_cs), .code_clear(code_clear), .code_out(code_out),
        .check_valid(check_valid), .stored_code(stored_code), .calc_code(calc_code),
        .fix_valid(fix_valid), .fix_status(fix_status),
        .fix_byte(fix_byte), .fix_bit(fix_bit)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // raw accumulator update: {hi, lo} un-inverted
    function automatic logic [23:0] fold(input logic [23:0] raw, input int idx,
                                         input logic [7:0] d);
        logic [11:0] hi, lo, p;
        hi = raw[23:12];
        lo = raw[11:0];
        for (int b = 0; b < 8; b++) begin
            if (d[b]) begin
                p  = 12'(idx * 8 + b);
                hi = hi ^ p;
                lo = lo ^ (12'hFFF ^ p);
            end
        end
        return {hi, lo};
    endfunction

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 101) ^ (i >> 2) ^ (seed << 3));
    endfunction

    task automatic push(input int cs, input logic [7:0] d);
        byte_valid = 1'b1;
        byte_cs    = 2'(cs);
        byte_data  = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic start(input logic [3:0] m);
        start_mask = m;
        @(negedge clk);
        start_mask = '0;
    endtask

    task automatic peek(input int cs, output logic [23:0] c);
        code_cs = 2'(cs);
        #1;
        c = code_out;
    endtask

    task automatic compare(input logic [23:0] s, input logic [23:0] c);
        stored_code = s;
        calc_code   = c;
        check_valid = 1'b1;
        @(negedge clk);
        check_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] c, rawA, rawB, rawC, rawR, codeA, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < NCS; k++) begin
            peek(k, c);
            check(c == 24'hFFFFFF, "R1 reset code", c, 24'hFFFFFF);
        end
        check(fix_valid == 1'b0, "R1 fix_valid", fix_valid, 0);

        // R2 erased sector
        start(4'b0001);
        for (int i = 0; i < SB; i++) push(0, 8'hFF);
        peek(0, c);
        check(c == 24'hFFFFFF, "R2 erased sector", c, 24'hFFFFFF);

        // R2 patterned sector on cs0
        start(4'b0001);
        rawA = '0;
        for (int i = 0; i < SB; i++) begin
            push(0, pat(i, 1));
            rawA = fold(rawA, i, pat(i, 1));
        end
        codeA = ~rawA;
        peek(0, c);
        check(c == codeA, "R2 sector code", c, codeA);

        // R5 bytes after the sector is full
        for (int i = 0; i < 5; i++) push(0, 8'h5A);
        peek(0, c);
        check(c == codeA, "R5 overrun ignored", c, codeA);

        // R4 interleaved contexts, cs3 unarmed
        start(4'b0110);
        rawB = '0;
        rawC = '0;
        for (int i = 0; i < SB; i++) begin
            push(1, pat(i, 2));
            rawB = fold(rawB, i, pat(i, 2));
            push(3, 8'hC3);
            push(2, pat(i, 3));
            rawC = fold(rawC, i, pat(i, 3));
        end
        peek(1, c);
        check(c == ~rawB, "R4 cs1 code", c, ~rawB);
        peek(2, c);
        check(c == ~rawC, "R4 cs2 code", c, ~rawC);
        peek(3, c);
        check(c == 24'hFFFFFF, "R4 unarmed cs3", c, 24'hFFFFFF);
        peek(0, c);
        check(c == codeA, "R7 cs0 view", c, codeA);

        // R6 clear and disarm
        code_cs    = 2'd0;
        code_clear = 1'b1;
        @(negedge clk);
        code_clear = 1'b0;
        peek(0, c);
        check(c == 24'hFFFFFF, "R6 cleared", c, 24'hFFFFFF);
        for (int i = 0; i < 8; i++) push(0, 8'h81);
        peek(0, c);
        check(c == 24'hFFFFFF, "R6 disarmed", c, 24'hFFFFFF);

        // R3 restart mid-sector on cs1
        for (int i = 0; i < 3; i++) push(1, 8'h11);
        start(4'b0010);
        rawR = '0;
        for (int i = 0; i < 10; i++) begin
            push(1, pat(i, 7));
            rawR = fold(rawR, i, pat(i, 7));
        end
        peek(1, c);
        check(c == ~rawR, "R3 restart", c, ~rawR);

        // R8 no error
        compare(codeA, codeA);
        check(fix_valid == 1'b1, "R8 valid", fix_valid, 1);
        check(fix_status == 2'd0, "R8 status", fix_status, 0);
        @(negedge clk);
        #1;
        check(fix_valid == 1'b0, "R8 valid drop", fix_valid, 0);

        // R9 every single data-bit position
        for (int p = 0; p < SB * 8; p++) begin
            logic [11:0] pp;
            pp = 12'(p);
            compare(codeA, codeA ^ {pp, ~pp});
            if (!(fix_status == 2'd1 && fix_byte == 9'(p / 8) && fix_bit == 3'(p % 8)))
                check(1'b0, "R9 data position", {fix_status, fix_byte, fix_bit},
                      {2'd1, 9'(p / 8), 3'(p % 8)});
            else
                check(1'b1, "R9 data position", 0, 0);
        end

        // R10 every single code-bit flip
        for (int j = 0; j < 24; j++) begin
            compare(codeA, codeA ^ (24'd1 << j));
            check(fix_status == 2'd2 && fix_byte == '0 && fix_bit == '0,
                  "R10 code bit", {fix_status, fix_byte, fix_bit}, {2'd2, 12'd0});
        end

        // R11 every double code-bit flip
        for (int i = 0; i < 24; i++) begin
            for (int j = i + 1; j < 24; j++) begin
                compare(codeA, codeA ^ (24'd1 << i) ^ (24'd1 << j));
                check(fix_status == 2'd3 && fix_byte == '0 && fix_bit == '0,
                      "R11 double bit", {fix_status, fix_byte, fix_bit}, {2'd3, 12'd0});
            end
        end

        // end-to-end: flip byte 300 bit 5 through cs3
        start(4'b1000);
        for (int i = 0; i < SB; i++) push(3, (i == 300) ? (pat(i, 1) ^ 8'h20) : pat(i, 1));
        peek(3, s);
        compare(codeA, s);
        check(fix_status == 2'd1 && fix_byte == 9'd300 && fix_bit == 3'd5,
              "R9 end to end", {fix_status, fix_byte, fix_bit}, {2'd1, 9'd300, 3'd5});

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule